// File: doc/BRIEF.md
# Precision-time event frame stamper

This unit sits on a byte-wide receive or transmit data path, after the nibbles from the media-independent interface have been assembled into bytes. Each frame begins with a start-of-frame flag on its first byte. On that same cycle the unit copies a free-running seconds and nanoseconds time input. It then follows the frame byte by byte to find where a Precision Time Protocol header begins. It handles four framings: plain Ethernet, Ethernet with one 802.1Q tag, IPv4 over UDP and IPv6 over UDP.

When the header is a version 2 event message, the unit produces one record. The record holds a 3-bit message tag, the latched time, the 64-bit clock identity, the 16-bit source port number and the 16-bit sequence id. It is presented with a one-cycle valid pulse. Software can later match a record to a frame by the identity, port and sequence fields. A one-step control input suppresses records for transmitted Sync and Pdelay_Resp frames, since in one-step operation those frames carry their own time.

Top module: `ptpcap_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rec_vld` is 0 and every record field reads 0.
- R2: `rec_sec` and `rec_ns` equal the values `tod_sec` and `tod_ns` had on the cycle that accepted the byte carrying `in_sof`. Later stalls or gaps do not change them.
- R3: Ethertype 0x88F7 in frame bytes 12–13 places the protocol header at byte 14.
- R4: Ethertype 0x8100 in bytes 12–13 adds 4 bytes. The real ethertype is then read from bytes 16–17, and every later offset moves by 4. A second 0x8100 tag drops the frame.
- R5: Ethertype 0x0800 selects IPv4. The IP header length is 4 times the low nibble of its first byte, and a value below 5 drops the frame. The protocol byte, IP header byte 9, must be 17. The UDP destination port, UDP bytes 2–3 in big-endian order, must be 319. The protocol header follows the 8-byte UDP header.
- R6: Ethertype 0x86DD selects IPv6. The next-header byte, IP header byte 6, must be 17. The UDP header starts 40 bytes after the IP header start, the destination port must be 319, and the protocol header follows 8 bytes later.
- R7: A record is produced only when the low nibble of header byte 0 (message type) is 0, 1, 2 or 3 and the low nibble of header byte 1 (version) is 2. The high nibbles are ignored.
- R8: `rec_tag` encodes message type 0 (Sync) as 1, type 2 (Pdelay_Req) as 2, type 3 (Pdelay_Resp) as 3 and type 1 (Delay_Req) as 4.
- R9: `rec_clkid` holds header bytes 20–27, `rec_port` holds bytes 28–29 and `rec_seq` holds bytes 30–31. All three are big-endian, with the first byte in the most significant position.
- R10: `rec_vld` pulses high for exactly one cycle, on the cycle after the unit accepts header byte 31. A frame whose last byte comes before header byte 31 produces no record, and a frame never produces more than one record, however long it runs.
- R11: When `in_tx` and `cfg_onestep` are both high on the byte that completes the sequence id, message types 0 and 3 produce no record. Types 1 and 2 are still recorded.
- R12: Bytes with `in_vld` low are skipped. A byte with `in_sof` high restarts parsing from byte 0, even in the middle of a frame. Bytes after an `in_eof` byte are ignored until the next `in_sof`.
- R13: Any other ethertype, UDP port or protocol produces no record. Between pulses the record outputs keep the last record's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_tx | input | 1 | High for the transmit direction |
| cfg_onestep | input | 1 | One-step operation enabled |
| tod_sec | input | SEC_W | Time input, seconds |
| tod_ns | input | NS_W | Time input, nanoseconds |
| rec_vld | output | 1 | Record valid pulse |
| rec_tag | output | 3 | Message tag code |
| rec_sec | output | SEC_W | Stamped seconds |
| rec_ns | output | NS_W | Stamped nanoseconds |
| rec_clkid | output | 64 | Clock identity |
| rec_port | output | 16 | Source port number |
| rec_seq | output | 16 | Sequence id |

## Verification
The bench builds the unit with IDX_W = 7, SEC_W = 48 and NS_W = 32. A 7-bit byte index makes the saturating counter reach its limit inside a 200-byte frame, so the bench can show that a long frame still yields exactly one record. The deepest header position, a tagged IPv4 frame with a 60-byte IP header whose last needed byte is 117, still fits below that limit. The 48-bit seconds and 32-bit nanoseconds widths carry time values wide enough to show that the full stamp is copied, not a truncated one.

// File: rtl/ptpcap_pkg.sv
package ptpcap_pkg;

  typedef enum logic [2:0] {
    ENC_NONE,
    ENC_L2,
    ENC_V4,
    ENC_V6,
    ENC_DROP
  } enc_e;

  localparam logic [15:0] ET_PTP  = 16'h88F7;
  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_IP4  = 16'h0800;
  localparam logic [15:0] ET_IP6  = 16'h86DD;
  localparam logic [7:0]  PROTO_UDP = 8'd17;

  localparam int ETH_HDR  = 14;
  localparam int VLAN_LEN = 4;
  localparam int IP6_HDR  = 40;
  localparam int UDP_HDR  = 8;

  localparam int OFS_TYPE  = 0;
  localparam int OFS_VER   = 1;
  localparam int OFS_CLK0  = 20;
  localparam int OFS_CLK7  = 27;
  localparam int OFS_PORTH = 28;
  localparam int OFS_PORTL = 29;
  localparam int OFS_SEQH  = 30;
  localparam int OFS_SEQL  = 31;

  // message type nibble -> record tag code
  function automatic logic [2:0] tag_of(input logic [3:0] mtype);
    case (mtype)
      4'd0:    tag_of = 3'd1;
      4'd1:    tag_of = 3'd4;
      4'd2:    tag_of = 3'd2;
      4'd3:    tag_of = 3'd3;
      default: tag_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ptpcap_locate.sv
module ptpcap_locate
  import ptpcap_pkg::*;
#(
  parameter int          IDX_W    = 11,
  parameter logic [15:0] EVT_PORT = 16'd319
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             byte_take,
  output logic [IDX_W-1:0] byte_idx,
  output logic             hdr_known,
  output logic [IDX_W-1:0] hdr_base
);

  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] L3_PLAIN = IDX_W'(ETH_HDR);
  localparam logic [IDX_W-1:0] L3_TAGD  = IDX_W'(ETH_HDR + VLAN_LEN);
  localparam logic [IDX_W-1:0] V6_SPAN  = IDX_W'(IP6_HDR);
  localparam logic [IDX_W-1:0] UDP_SPAN = IDX_W'(UDP_HDR);

  logic             active_q;
  logic [IDX_W-1:0] cnt_q;
  enc_e             enc_q;
  logic             vlan_q;
  logic [IDX_W-1:0] l3_q;
  logic [IDX_W-1:0] udp_q;
  logic             udp_known_q;
  logic             hdr_known_q;
  logic [IDX_W-1:0] hdr_base_q;
  logic [7:0]       hold_q;

  logic             take;
  logic [IDX_W-1:0] idx;
  enc_e             enc_cur;
  logic             vlan_cur;
  logic [IDX_W-1:0] l3_cur;
  logic             udp_known_cur;
  logic [15:0]      word_cur;

  always_comb begin
    take          = in_vld && (in_sof || active_q);
    idx           = in_sof ? '0 : cnt_q;
    enc_cur       = in_sof ? ENC_NONE : enc_q;
    vlan_cur      = in_sof ? 1'b0 : vlan_q;
    l3_cur        = in_sof ? L3_PLAIN : l3_q;
    udp_known_cur = !in_sof && udp_known_q;
    word_cur      = {hold_q, in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      cnt_q       <= '0;
      enc_q       <= ENC_NONE;
      vlan_q      <= 1'b0;
      l3_q        <= L3_PLAIN;
      udp_q       <= '0;
      udp_known_q <= 1'b0;
      hdr_known_q <= 1'b0;
      hdr_base_q  <= '0;
      hold_q      <= '0;
    end else if (take) begin
      active_q <= !in_eof;
      cnt_q    <= (idx == IDX_MAX) ? idx : idx + 1'b1;
      if (in_sof) begin
        enc_q       <= ENC_NONE;
        vlan_q      <= 1'b0;
        l3_q        <= L3_PLAIN;
        udp_known_q <= 1'b0;
        hdr_known_q <= 1'b0;
      end
      // ethertype high byte
      if (idx == l3_cur - IDX_W'(2)) hold_q <= in_data;
      // ethertype decode
      if (idx == l3_cur - IDX_W'(1) && enc_cur == ENC_NONE) begin
        if (word_cur == ET_VLAN) begin
          if (vlan_cur) enc_q <= ENC_DROP;
          else begin
            vlan_q <= 1'b1;
            l3_q   <= L3_TAGD;
          end
        end else if (word_cur == ET_PTP) begin
          enc_q       <= ENC_L2;
          hdr_known_q <= 1'b1;
          hdr_base_q  <= l3_cur;
        end else if (word_cur == ET_IP4) begin
          enc_q <= ENC_V4;
        end else if (word_cur == ET_IP6) begin
          enc_q       <= ENC_V6;
          udp_q       <= l3_cur + V6_SPAN;
          udp_known_q <= 1'b1;
        end else begin
          enc_q <= ENC_DROP;
        end
      end
      // IPv4 header length and protocol
      if (enc_cur == ENC_V4 && idx == l3_cur) begin
        if (in_data[3:0] < 4'd5) enc_q <= ENC_DROP;
        else begin
          udp_q       <= l3_cur + IDX_W'({in_data[3:0], 2'b00});
          udp_known_q <= 1'b1;
        end
      end
      if (enc_cur == ENC_V4 && idx == l3_cur + IDX_W'(9) && in_data != PROTO_UDP)
        enc_q <= ENC_DROP;
      // IPv6 next header
      if (enc_cur == ENC_V6 && idx == l3_cur + IDX_W'(6) && in_data != PROTO_UDP)
        enc_q <= ENC_DROP;
      // UDP destination port
      if (udp_known_cur && enc_cur != ENC_DROP) begin
        if (idx == udp_q + IDX_W'(2)) hold_q <= in_data;
        if (idx == udp_q + IDX_W'(3)) begin
          if (word_cur == EVT_PORT) begin
            hdr_known_q <= 1'b1;
            hdr_base_q  <= udp_q + UDP_SPAN;
          end else begin
            enc_q <= ENC_DROP;
          end
        end
      end
    end
  end

  assign byte_take = take;
  assign byte_idx  = idx;
  assign hdr_known = hdr_known_q && !in_sof;
  assign hdr_base  = hdr_base_q;

endmodule

// File: rtl/ptpcap_extract.sv
module ptpcap_extract
  import ptpcap_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int SEC_W = 48,
  parameter int NS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_take,
  input  logic             byte_sof,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       byte_data,
  input  logic             hdr_known,
  input  logic [IDX_W-1:0] hdr_base,
  input  logic             dir_tx,
  input  logic             onestep,
  input  logic [SEC_W-1:0] stamp_sec,
  input  logic [NS_W-1:0]  stamp_ns,
  output logic             rec_vld,
  output logic [2:0]       rec_tag,
  output logic [SEC_W-1:0] rec_sec,
  output logic [NS_W-1:0]  rec_ns,
  output logic [63:0]      rec_clkid,
  output logic [15:0]      rec_port,
  output logic [15:0]      rec_seq
);

  logic [3:0]       mtype_q;
  logic             ver_ok_q;
  logic [63:0]      cid_q;
  logic [15:0]      port_q;
  logic [7:0]       seqh_q;
  logic             done_q;

  logic             in_hdr;
  logic [IDX_W-1:0] rel;
  logic             kind_ok;
  logic             skip_1s;
  logic             emit;

  always_comb begin
    rel     = byte_idx - hdr_base;
    in_hdr  = byte_take && hdr_known && (byte_idx >= hdr_base) && !done_q;
    kind_ok = (mtype_q <= 4'd3) && ver_ok_q;
    skip_1s = dir_tx && onestep && (mtype_q == 4'd0 || mtype_q == 4'd3);
    emit    = in_hdr && rel == IDX_W'(OFS_SEQL) && kind_ok && !skip_1s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mtype_q   <= '0;
      ver_ok_q  <= 1'b0;
      cid_q     <= '0;
      port_q    <= '0;
      seqh_q    <= '0;
      done_q    <= 1'b0;
      rec_vld   <= 1'b0;
      rec_tag   <= '0;
      rec_sec   <= '0;
      rec_ns    <= '0;
      rec_clkid <= '0;
      rec_port  <= '0;
      rec_seq   <= '0;
    end else begin
      rec_vld <= emit;
      if (byte_take && byte_sof) done_q <= 1'b0;
      if (in_hdr) begin
        if (rel == IDX_W'(OFS_TYPE)) mtype_q <= byte_data[3:0];
        if (rel == IDX_W'(OFS_VER))  ver_ok_q <= (byte_data[3:0] == 4'd2);
        if (rel >= IDX_W'(OFS_CLK0) && rel <= IDX_W'(OFS_CLK7))
          cid_q <= {cid_q[55:0], byte_data};
        if (rel == IDX_W'(OFS_PORTH)) port_q[15:8] <= byte_data;
        if (rel == IDX_W'(OFS_PORTL)) port_q[7:0]  <= byte_data;
        if (rel == IDX_W'(OFS_SEQH))  seqh_q <= byte_data;
        if (rel == IDX_W'(OFS_SEQL))  done_q <= 1'b1;
      end
      if (emit) begin
        rec_tag   <= tag_of(mtype_q);
        rec_sec   <= stamp_sec;
        rec_ns    <= stamp_ns;
        rec_clkid <= cid_q;
        rec_port  <= port_q;
        rec_seq   <= {seqh_q, byte_data};
      end
    end
  end

endmodule

// File: rtl/ptpcap_unit.sv
module ptpcap_unit
  import ptpcap_pkg::*;
#(
  parameter int          IDX_W    = 11,
  parameter int          SEC_W    = 48,
  parameter int          NS_W     = 32,
  parameter logic [15:0] EVT_PORT = 16'd319
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             in_tx,
  input  logic             cfg_onestep,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  output logic             rec_vld,
  output logic [2:0]       rec_tag,
  output logic [SEC_W-1:0] rec_sec,
  output logic [NS_W-1:0]  rec_ns,
  output logic [63:0]      rec_clkid,
  output logic [15:0]      rec_port,
  output logic [15:0]      rec_seq
);

  logic             byte_take;
  logic [IDX_W-1:0] byte_idx;
  logic             hdr_known;
  logic [IDX_W-1:0] hdr_base;
  logic [SEC_W-1:0] sof_sec_q;
  logic [NS_W-1:0]  sof_ns_q;

  // time copy on the first byte
  always_ff @(posedge clk) begin
    if (rst) begin
      sof_sec_q <= '0;
      sof_ns_q  <= '0;
    end else if (byte_take && in_sof) begin
      sof_sec_q <= tod_sec;
      sof_ns_q  <= tod_ns;
    end
  end

  ptpcap_locate #(.IDX_W(IDX_W), .EVT_PORT(EVT_PORT)) u_locate (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .byte_take (byte_take),
    .byte_idx  (byte_idx),
    .hdr_known (hdr_known),
    .hdr_base  (hdr_base)
  );

  ptpcap_extract #(.IDX_W(IDX_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_extract (
    .clk       (clk),
    .rst       (rst),
    .byte_take (byte_take),
    .byte_sof  (in_sof),
    .byte_idx  (byte_idx),
    .byte_data (in_data),
    .hdr_known (hdr_known),
    .hdr_base  (hdr_base),
    .dir_tx    (in_tx),
    .onestep   (cfg_onestep),
    .stamp_sec (sof_sec_q),
    .stamp_ns  (sof_ns_q),
    .rec_vld   (rec_vld),
    .rec_tag   (rec_tag),
    .rec_sec   (rec_sec),
    .rec_ns    (rec_ns),
    .rec_clkid (rec_clkid),
    .rec_port  (rec_port),
    .rec_seq   (rec_seq)
  );

endmodule

// File: rtl/ptpcap_unit_chk.sv
module ptpcap_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic        in_tx,
  input logic        cfg_onestep,
  input logic        rec_vld,
  input logic [2:0]  rec_tag,
  input logic [63:0] rec_clkid,
  input logic [15:0] rec_port,
  input logic [15:0] rec_seq
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !rec_vld);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rec_vld |=> !rec_vld);

  // R8
  tag_code_chk: assert property (@(posedge clk) disable iff (rst)
    rec_vld |-> (rec_tag >= 3'd1 && rec_tag <= 3'd4));

  // R11
  onestep_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && $past(in_tx && cfg_onestep)) |-> (rec_tag == 3'd2 || rec_tag == 3'd4));

  // R12
  byte_source_chk: assert property (@(posedge clk) disable iff (rst)
    rec_vld |-> $past(in_vld));

  // R13
  record_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rec_vld && !$past(rst)) |-> ($stable(rec_seq) && $stable(rec_port) && $stable(rec_clkid)));

endmodule

bind ptpcap_unit ptpcap_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_vld      (in_vld),
  .in_tx       (in_tx),
  .cfg_onestep (cfg_onestep),
  .rec_vld     (rec_vld),
  .rec_tag     (rec_tag),
  .rec_clkid   (rec_clkid),
  .rec_port    (rec_port),
  .rec_seq     (rec_seq)
);

// File: tb/ptpcap_unit_tb.sv
`timescale 1ns/1ps
module ptpcap_unit_tb;

  localparam int IDX_W = 7;
  localparam int SEC_W = 48;
  localparam int NS_W  = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst;
  logic             in_vld, in_sof, in_eof, in_tx, cfg_onestep;
  logic [7:0]       in_data;
  logic [SEC_W-1:0] tod_sec;
  logic [NS_W-1:0]  tod_ns;
  logic             rec_vld;
  logic [2:0]       rec_tag;
  logic [SEC_W-1:0] rec_sec;
  logic [NS_W-1:0]  rec_ns;
  logic [63:0]      rec_clkid;
  logic [15:0]      rec_port, rec_seq;

  ptpcap_unit #(.IDX_W(IDX_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_tx(in_tx), .cfg_onestep(cfg_onestep),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .rec_vld(rec_vld), .rec_tag(rec_tag),
    .rec_sec(rec_sec), .rec_ns(rec_ns), .rec_clkid(rec_clkid),
    .rec_port(rec_port), .rec_seq(rec_seq)
  );

  // free-running time source
  initial begin
    tod_sec = 48'h0000_1234_5678;
    tod_ns  = 32'd999_999_000;
  end
  always @(posedge clk) begin
    if (tod_ns >= 32'd999_999_996) begin
      tod_ns  <= 32'd0;
      tod_sec <= tod_sec + 1'b1;
    end else begin
      tod_ns <= tod_ns + 32'd4;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] held_seq = 16'd0;
  logic [63:0] held_cid = 64'd0;
  logic [7:0]  frm[$];

  task automatic check_cycle(input bit ev, input logic [2:0] et, input logic [SEC_W-1:0] es,
                             input logic [NS_W-1:0] en, input logic [63:0] ec,
                             input logic [15:0] ep, input logic [15:0] eq, input string req);
    n_cmp++;
    if (rec_vld !== ev) begin
      n_bad++;
      $display("FAIL %s rec_vld got %0b exp %0b", req, rec_vld, ev);
    end else if (ev) begin
      if ({rec_tag, rec_sec, rec_ns, rec_clkid, rec_port, rec_seq} !== {et, es, en, ec, ep, eq}) begin
        n_bad++;
        $display("FAIL %s record got tag=%0d s=%h ns=%0d c=%h p=%h q=%h exp tag=%0d s=%h ns=%0d c=%h p=%h q=%h",
                 req, rec_tag, rec_sec, rec_ns, rec_clkid, rec_port, rec_seq,
                 et, es, en, ec, ep, eq);
      end
      held_seq = eq;
      held_cid = ec;
    end else if (rec_seq !== held_seq || rec_clkid !== held_cid) begin
      n_bad++;
      $display("FAIL R13 held record got q=%h c=%h exp q=%h c=%h", rec_seq, rec_clkid, held_seq, held_cid);
    end
  endtask

  task automatic idle(input int n, input string req);
    repeat (n) begin
      in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      @(posedge clk); @(negedge clk);
      check_cycle(1'b0, 3'd0, '0, '0, 64'd0, 16'd0, 16'd0, req);
    end
  endtask

  // kind: 0 raw, 1 IPv4, 2 IPv6, 3 other ethertype
  task automatic build(input int kind, input bit vlan, input logic [3:0] mt, input logic [3:0] ver,
                       input logic [15:0] sq, input int ihl, input logic [15:0] dport,
                       input logic [7:0] proto, input int pad_to);
    logic [63:0] cid;
    logic [15:0] pn;
    cid = {16'hC1D0, sq, 32'h0BAD_F00D ^ {16'd0, sq}};
    pn  = sq ^ 16'h0F0F;
    frm.delete();
    for (int i = 0; i < 12; i++) frm.push_back(8'(i + 1));
    if (vlan) begin
      frm.push_back(8'h81); frm.push_back(8'h00); frm.push_back(8'h00); frm.push_back(8'h05);
    end
    case (kind)
      0: begin frm.push_back(8'h88); frm.push_back(8'hF7); end
      1: begin frm.push_back(8'h08); frm.push_back(8'h00); end
      2: begin frm.push_back(8'h86); frm.push_back(8'hDD); end
      default: begin frm.push_back(8'h08); frm.push_back(8'h06); end
    endcase
    if (kind == 1) begin
      frm.push_back(8'h40 | 8'(ihl));
      for (int i = 1; i < ihl * 4; i++) frm.push_back(i == 9 ? proto : 8'h00);
    end else if (kind == 2) begin
      for (int i = 0; i < 40; i++) frm.push_back(i == 6 ? proto : 8'h00);
    end
    if (kind == 1 || kind == 2) begin
      frm.push_back(8'h01); frm.push_back(8'h3F);
      frm.push_back(dport[15:8]); frm.push_back(dport[7:0]);
      for (int i = 0; i < 4; i++) frm.push_back(8'h00);
    end
    frm.push_back({4'h1, mt});
    frm.push_back({4'h0, ver});
    for (int i = 2; i < 20; i++) frm.push_back(8'hE0 + 8'(i));
    for (int i = 7; i >= 0; i--) frm.push_back(cid[i*8 +: 8]);
    frm.push_back(pn[15:8]); frm.push_back(pn[7:0]);
    frm.push_back(sq[15:8]); frm.push_back(sq[7:0]);
    for (int i = 0; i < 10; i++) frm.push_back(8'h00);
    while (frm.size() < pad_to) frm.push_back(8'h00);
  endtask

  task automatic trunc(input int n);
    while (frm.size() > n) void'(frm.pop_back());
  endtask

  // reference: parse the byte list from the requirements
  task automatic ref_eval(input bit tx, input bit os, input bit nosof, output bit hit, output int last,
                          output logic [2:0] tag, output logic [63:0] cid,
                          output logic [15:0] pn, output logic [15:0] sq);
    int n, l3, et, ph, u, ihl, mt;
    hit = 1'b0; last = -1; tag = 3'd0; cid = 64'd0; pn = 16'd0; sq = 16'd0;
    n = frm.size(); ph = -1;
    if (nosof || n < 14) return;
    l3 = 14;
    et = {frm[12], frm[13]};
    if (et == 16'h8100) begin
      if (n < 18) return;
      l3 = 18;
      et = {frm[16], frm[17]};
    end
    if (et == 16'h88F7) ph = l3;
    else if (et == 16'h0800) begin
      ihl = int'(frm[l3][3:0]);
      if (ihl < 5) return;
      u = l3 + ihl * 4;
      if (n < u + 8) return;
      if (frm[l3 + 9] != 8'd17) return;
      if ({frm[u + 2], frm[u + 3]} != 16'd319) return;
      ph = u + 8;
    end else if (et == 16'h86DD) begin
      u = l3 + 40;
      if (n < u + 8) return;
      if (frm[l3 + 6] != 8'd17) return;
      if ({frm[u + 2], frm[u + 3]} != 16'd319) return;
      ph = u + 8;
    end else return;
    if (n < ph + 32) return;
    mt = int'(frm[ph][3:0]);
    if (mt > 3) return;
    if (frm[ph + 1][3:0] != 4'd2) return;
    if (tx && os && (mt == 0 || mt == 3)) return;
    case (mt)
      0: tag = 3'd1;
      1: tag = 3'd4;
      2: tag = 3'd2;
      default: tag = 3'd3;
    endcase
    for (int i = 0; i < 8; i++) cid = {cid[55:0], frm[ph + 20 + i]};
    pn   = {frm[ph + 28], frm[ph + 29]};
    sq   = {frm[ph + 30], frm[ph + 31]};
    last = ph + 31;
    hit  = 1'b1;
  endtask

  task automatic send(input bit tx, input bit os, input bit nosof, input bit with_eof,
                      input int gap, input string req);
    bit hit;
    int last;
    logic [2:0]       tg;
    logic [63:0]      cid;
    logic [15:0]      pn, sq;
    logic [SEC_W-1:0] ssec;
    logic [NS_W-1:0]  sns;
    ref_eval(tx, os, nosof, hit, last, tg, cid, pn, sq);
    ssec = '0; sns = '0;
    for (int i = 0; i < frm.size(); i++) begin
      in_vld = 1'b1;
      in_sof = (i == 0) && !nosof;
      in_eof = with_eof && (i == frm.size() - 1);
      in_data = frm[i];
      in_tx = tx;
      cfg_onestep = os;
      if (i == 0) begin ssec = tod_sec; sns = tod_ns; end
      @(posedge clk); @(negedge clk);
      check_cycle(hit && i == last, tg, ssec, sns, cid, pn, sq, req);
      if (gap > 0 && (i % 3) == 1) begin
        in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hA5;
        repeat (gap) begin
          @(posedge clk); @(negedge clk);
          check_cycle(1'b0, 3'd0, '0, '0, 64'd0, 16'd0, 16'd0, req);
        end
      end
    end
    in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    in_tx = 1'b0; cfg_onestep = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_cycle(1'b0, 3'd0, '0, '0, 64'd0, 16'd0, 16'd0, "R1");
    if (rec_sec !== '0 || rec_ns !== '0 || rec_port !== 16'd0 || rec_tag !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 fields got s=%h ns=%h p=%h t=%0d exp all 0", rec_sec, rec_ns, rec_port, rec_tag);
    end
    n_cmp++;
    idle(2, "R1");

    build(0, 0, 4'd0, 4'd2, 16'h0101, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R3 R8 R9 R2");
    idle(3, "R10");
    build(0, 1, 4'd1, 4'd2, 16'h0202, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R4 R8");
    build(1, 0, 4'd2, 4'd2, 16'h0303, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R5 R8");
    build(1, 0, 4'd3, 4'd2, 16'h0404, 6, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R5 R9");
    build(1, 1, 4'd1, 4'd2, 16'h0505, 15, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R4 R5");
    build(2, 0, 4'd0, 4'd2, 16'h0606, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R6");
    build(2, 1, 4'd3, 4'd2, 16'h0707, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R6 R4");
    idle(2, "R13");
    // rejected frames
    build(0, 0, 4'd0, 4'd1, 16'h0808, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R7");
    build(0, 0, 4'd8, 4'd2, 16'h0909, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R7");
    build(1, 0, 4'd0, 4'd2, 16'h0A0A, 5, 16'd320, 8'd17, 64); send(0, 0, 0, 1, 0, "R13");
    build(1, 0, 4'd0, 4'd2, 16'h0B0B, 5, 16'd319, 8'd6, 64);  send(0, 0, 0, 1, 0, "R5");
    build(1, 0, 4'd0, 4'd2, 16'h0B0C, 4, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R5");
    build(2, 0, 4'd0, 4'd2, 16'h0C0C, 5, 16'd319, 8'd6, 64);  send(0, 0, 0, 1, 0, "R6");
    build(3, 0, 4'd0, 4'd2, 16'h0D0D, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R13");
    // truncation around the sequence id
    build(0, 0, 4'd0, 4'd2, 16'h0E0E, 5, 16'd319, 8'd17, 64); trunc(14 + 31); send(0, 0, 0, 1, 0, "R10");
    build(0, 0, 4'd0, 4'd2, 16'h0F0F, 5, 16'd319, 8'd17, 64); trunc(14 + 32); send(0, 0, 0, 1, 0, "R10");
    // one-step
    build(0, 0, 4'd0, 4'd2, 16'h1010, 5, 16'd319, 8'd17, 64); send(1, 1, 0, 1, 0, "R11");
    build(1, 0, 4'd3, 4'd2, 16'h1111, 5, 16'd319, 8'd17, 64); send(1, 1, 0, 1, 0, "R11");
    build(0, 0, 4'd2, 4'd2, 16'h1212, 5, 16'd319, 8'd17, 64); send(1, 1, 0, 1, 0, "R11");
    build(0, 0, 4'd1, 4'd2, 16'h1313, 5, 16'd319, 8'd17, 64); send(1, 1, 0, 1, 0, "R11");
    build(0, 0, 4'd0, 4'd2, 16'h1414, 5, 16'd319, 8'd17, 64); send(0, 1, 0, 1, 0, "R11");
    build(0, 0, 4'd3, 4'd2, 16'h1515, 5, 16'd319, 8'd17, 64); send(1, 0, 0, 1, 0, "R11");
    // stalls, restart, stray bytes
    build(1, 1, 4'd2, 4'd2, 16'h1616, 7, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 2, "R12 R2");
    build(0, 0, 4'd0, 4'd2, 16'h1717, 5, 16'd319, 8'd17, 64); trunc(30); send(0, 0, 0, 0, 0, "R12");
    build(0, 0, 4'd3, 4'd2, 16'h1818, 5, 16'd319, 8'd17, 64); send(0, 0, 0, 1, 0, "R12");
    build(0, 0, 4'd0, 4'd2, 16'h1919, 5, 16'd319, 8'd17, 64); send(0, 0, 1, 1, 0, "R12");
    // long frame past the index limit
    build(0, 0, 4'd1, 4'd2, 16'h1A1A, 5, 16'd319, 8'd17, 200); send(0, 0, 0, 1, 0, "R10");
    idle(4, "R13");
    finish_run();
  end

endmodule